// File: doc/BRIEF.md
# Supervisory Reset Pulse Generator

This block merges several reset causes into a single active-low system reset with a programmable hold-off. It watches a digital undervoltage flag and a supply-recovered flag (which already includes the comparator's hysteresis), an asynchronous active-low manual reset button and a one-cycle watchdog fault strobe. The system reset is held low while any cause is active. After the last cause clears, it stays low for a hold-off whose length is set by a register input. Everything runs from one free-running timebase clock.

Short disturbances are filtered before they can reach the output. The undervoltage flag has to stay high for a programmable number of consecutive cycles before it counts as a brownout. Once a brownout is latched, only the recovered flag can end it, so the release timing starts at threshold plus hysteresis and not at the bare threshold. The manual reset input passes through a two-flop synchronizer and then a persistence filter, so presses shorter than a fixed minimum width are dropped. A watchdog strobe does not act as a level. Instead it produces one reset pulse exactly one hold-off long. Any cause that reappears during the hold-off restarts it from the full length.

The undervoltage and recovered flags are taken as synchronous to the clock. The manual reset input may be asynchronous.

Top module: `sup_reset_gen`

## Requirements
- R1: While `rst_n` is low, `sys_rst_n` is low. After `rst_n` is released, `sys_rst_n` stays low for exactly H clock cycles and then goes high. H is `cfg_hold_len` read as an unsigned cycle count, with 0 treated as 1.
- R2: A `wd_fault` that is high for one clock, with no other cause active, drives `sys_rst_n` low in the cycle after it is sampled and keeps it low for exactly H cycles.
- R3: A `mr_n` low run of L consecutive sampled cycles with L >= MR_MIN_W is accepted. `sys_rst_n` falls MR_MIN_W+3 clocks after the first low sample and stays low for L - MR_MIN_W + H cycles.
- R4: A `mr_n` low run shorter than MR_MIN_W sampled cycles leaves `sys_rst_n` high.
- R5: A high run of `uv_flag` shorter than N consecutive cycles is ignored. A run of N or more latches a brownout. N is `cfg_uv_qual` read as unsigned, with 0 treated as 1.
- R6: A latched brownout ends only in a cycle where `ok_hyst` is high and the qualified dip has cleared. Suppose `uv_flag` is high for D >= N cycles and `ok_hyst` is low for D+G cycles (G >= 1) from the same start. Then the low pulse on `sys_rst_n` lasts D + G - N + H - 1 cycles.
- R7: A cause that reappears while the hold-off runs reloads it to the full length. Two watchdog strobes sampled k cycles apart (0 < k < H) give one pulse of k + H cycles.
- R8: When causes overlap, `sys_rst_n` rises only H cycles after the last active cause was sampled. A watchdog strobe during a held manual reset does not change the R3 pulse length.
- R9: With `cfg_hold_len` = 0, a single watchdog strobe gives a one-cycle reset pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running timebase clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| uv_flag | input | 1 | Supply below falling threshold (synchronous) |
| ok_hyst | input | 1 | Supply above threshold plus hysteresis (synchronous) |
| mr_n | input | 1 | Manual reset, active low, asynchronous |
| wd_fault | input | 1 | Watchdog fault strobe, one clock wide |
| cfg_hold_len | input | HOLD_W | Hold-off length in cycles |
| cfg_uv_qual | input | QUAL_W | Undervoltage qualification length in cycles |
| sys_rst_n | output | 1 | Combined active-low system reset |

## Verification
A hold-off counter that is loaded or decremented wrongly shows up directly as a reset pulse that is too short or too long, and that is visible as soon as the pulse ends. A persistence counter that mis-counts makes `sys_rst_n` fall a few cycles early or late, or makes a glitch produce a pulse it should not. A brownout latch that clears too early or too late shifts the rising edge of `sys_rst_n` against `ok_hyst` by the same number of cycles. Every scenario is therefore judged by the exact length of each low pulse and by quiet windows after stimuli that must be rejected.

// File: rtl/sup_reset_pkg.sv
package sup_reset_pkg;

    // Cause vector layout used between the front end and the hold timer
    localparam int unsigned NUM_SRC = 3;
    localparam int unsigned SRC_UV  = 0;
    localparam int unsigned SRC_MR  = 1;
    localparam int unsigned SRC_WD  = 2;

    // Bits needed to hold values 0..max_val
    function automatic int unsigned cnt_width(input int unsigned max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/sup_reset_sync.sv
module sup_reset_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int unsigned DEPTH = (STAGES < 2) ? 2 : STAGES;

    logic [DEPTH-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[DEPTH-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= {DEPTH{RST_VAL}};
        end else begin
            sh_q <= sh_d;
        end
    end

    assign dout = sh_q[DEPTH-1];

endmodule

// File: rtl/sup_reset_persist.sv
// Persistence filter: hit is high in the cycle after din has been sampled
// high on lim consecutive edges (lim of 0 acts as 1), and it stays high
// until din is sampled low.
module sup_reset_persist #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             din,
    input  logic [CNT_W-1:0] lim,
    output logic             hit
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             hit;
    } st_t;

    st_t          st_d, st_q;
    logic [CNT_W:0] run_next;

    always_comb begin
        st_d     = st_q;
        st_d.hit = 1'b0;
        run_next = {1'b0, st_q.cnt} + {{CNT_W{1'b0}}, 1'b1};
        if (!din) begin
            st_d.cnt = '0;
        end else if (run_next >= {1'b0, lim}) begin
            st_d.hit = 1'b1;
        end else begin
            st_d.cnt = run_next[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hit = st_q.hit;

endmodule

// File: rtl/sup_reset_uv_track.sv
// Brownout tracker: a qualified dip sets the latch; only the recovered
// (hysteresis) flag clears it, and a fresh qualified dip wins.
module sup_reset_uv_track #(
    parameter int unsigned QUAL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              uv_flag,
    input  logic              ok_hyst,
    input  logic [QUAL_W-1:0] qual_len,
    output logic              uv_active
);
    typedef struct packed {
        logic low_supply;
    } st_t;

    st_t  st_d, st_q;
    logic dip_hit;

    sup_reset_persist #(
        .CNT_W (QUAL_W)
    ) u_dip_qual (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (uv_flag),
        .lim   (qual_len),
        .hit   (dip_hit)
    );

    always_comb begin
        st_d = st_q;
        if (dip_hit) begin
            st_d.low_supply = 1'b1;
        end else if (ok_hyst) begin
            st_d.low_supply = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign uv_active = st_q.low_supply;

endmodule

// File: rtl/sup_reset_hold.sv
// Hold-off timer: any active cause reloads the count to hold_len-1 and
// forces the output low; the output rises once the count has run out.
module sup_reset_hold
    import sup_reset_pkg::*;
#(
    parameter int unsigned HOLD_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src,
    input  logic [HOLD_W-1:0]  hold_len,
    output logic               rst_out_n,
    output logic               cond_any,
    output logic [HOLD_W-1:0]  remain
);
    typedef struct packed {
        logic [HOLD_W-1:0] cnt;
        logic              out_n;
        logic              boot;
    } st_t;

    st_t               st_d, st_q;
    logic [HOLD_W-1:0] reload;

    always_comb begin
        reload   = (hold_len == '0) ? '0
                 : hold_len - {{(HOLD_W-1){1'b0}}, 1'b1};
        cond_any = (|src) | st_q.boot;

        st_d      = st_q;
        st_d.boot = 1'b0;
        if (cond_any) begin
            st_d.cnt   = reload;
            st_d.out_n = 1'b0;
        end else if (st_q.cnt != '0) begin
            st_d.cnt   = st_q.cnt - {{(HOLD_W-1){1'b0}}, 1'b1};
            st_d.out_n = 1'b0;
        end else begin
            st_d.out_n = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt   <= '0;
            st_q.out_n <= 1'b0;
            st_q.boot  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rst_out_n = st_q.out_n;
    assign remain    = st_q.cnt;

endmodule

// File: rtl/sup_reset_gen.sv
module sup_reset_gen
    import sup_reset_pkg::*;
#(
    parameter int unsigned HOLD_W      = 16,
    parameter int unsigned QUAL_W      = 8,
    parameter int unsigned MR_MIN_W    = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              uv_flag,
    input  logic              ok_hyst,
    input  logic              mr_n,
    input  logic              wd_fault,
    input  logic [HOLD_W-1:0] cfg_hold_len,
    input  logic [QUAL_W-1:0] cfg_uv_qual,
    output logic              sys_rst_n
);
    localparam int unsigned      MR_CW  = cnt_width(MR_MIN_W);
    localparam logic [MR_CW-1:0] MR_LIM = MR_CW'(MR_MIN_W);

    logic               mr_sync_n;
    logic               mr_hit;
    logic               uv_active;
    logic               cond_any;
    logic [HOLD_W-1:0]  hold_remain;
    logic [NUM_SRC-1:0] src_vec;

    // Manual reset: synchronize, then require a minimum low width
    sup_reset_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) u_mr_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (mr_n),
        .dout  (mr_sync_n)
    );

    sup_reset_persist #(
        .CNT_W (MR_CW)
    ) u_mr_filt (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (~mr_sync_n),
        .lim   (MR_LIM),
        .hit   (mr_hit)
    );

    // Supply: qualified dip plus hysteresis release
    sup_reset_uv_track #(
        .QUAL_W (QUAL_W)
    ) u_uv (
        .clk       (clk),
        .rst_n     (rst_n),
        .uv_flag   (uv_flag),
        .ok_hyst   (ok_hyst),
        .qual_len  (cfg_uv_qual),
        .uv_active (uv_active)
    );

    always_comb begin
        src_vec         = '0;
        src_vec[SRC_UV] = uv_active;
        src_vec[SRC_MR] = mr_hit;
        src_vec[SRC_WD] = wd_fault;
    end

    sup_reset_hold #(
        .HOLD_W (HOLD_W)
    ) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .src       (src_vec),
        .hold_len  (cfg_hold_len),
        .rst_out_n (sys_rst_n),
        .cond_any  (cond_any),
        .remain    (hold_remain)
    );

endmodule

// File: rtl/sup_reset_gen_chk.sv
module sup_reset_gen_chk #(
    parameter int unsigned HOLD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wd_fault,
    input logic              ok_hyst,
    input logic              sys_rst_n,
    input logic              mr_hit,
    input logic              uv_active,
    input logic              cond_any,
    input logic [HOLD_W-1:0] hold_remain
);

    // R1: a released output means the hold-off has fully run out
    assert_idle_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_n |-> (hold_remain == '0))
        else $error("R1 output high with hold-off pending");

    // R2: a watchdog strobe pulls the reset low on the next cycle
    assert_wd_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wd_fault |=> !sys_rst_n)
        else $error("R2 watchdog strobe did not assert reset");

    // R3: an accepted manual press keeps the reset low
    assert_mr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mr_hit |=> !sys_rst_n)
        else $error("R3 accepted manual reset did not assert reset");

    // R6: a latched brownout without the recovered flag keeps reset low
    assert_uv_hyst_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (uv_active && !ok_hyst) |=> !sys_rst_n)
        else $error("R6 brownout released before hysteresis");

    // R8: release only follows a cycle with no active cause
    assert_release_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_n) |-> !$past(cond_any))
        else $error("R8 release while a cause was active");

endmodule

bind sup_reset_gen sup_reset_gen_chk #(
    .HOLD_W (HOLD_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wd_fault    (wd_fault),
    .ok_hyst     (ok_hyst),
    .sys_rst_n   (sys_rst_n),
    .mr_hit      (mr_hit),
    .uv_active   (uv_active),
    .cond_any    (cond_any),
    .hold_remain (hold_remain)
);

// File: tb/sup_reset_gen_tb.sv
module sup_reset_gen_tb;
    localparam int HOLD_W   = 16;
    localparam int QUAL_W   = 8;
    localparam int MR_MIN_W = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              uv_flag = 1'b0;
    logic              ok_hyst = 1'b1;
    logic              mr_n = 1'b1;
    logic              wd_fault = 1'b0;
    logic [HOLD_W-1:0] cfg_hold_len = 16'd20;
    logic [QUAL_W-1:0] cfg_uv_qual = 8'd5;
    logic              sys_rst_n;

    int    checks = 0;
    int    fails = 0;
    bit    finished = 1'b0;
    bit    mon_en = 1'b0;
    string quiet_req = "R8";
    int    run_len = 0;

    typedef struct {
        int    len;
        string req;
    } exp_t;
    exp_t exp_q[$];

    always #4 clk = ~clk;  // 125 MHz

    sup_reset_gen #(
        .HOLD_W   (HOLD_W),
        .QUAL_W   (QUAL_W),
        .MR_MIN_W (MR_MIN_W)
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .uv_flag      (uv_flag),
        .ok_hyst      (ok_hyst),
        .mr_n         (mr_n),
        .wd_fault     (wd_fault),
        .cfg_hold_len (cfg_hold_len),
        .cfg_uv_qual  (cfg_uv_qual),
        .sys_rst_n    (sys_rst_n)
    );

    function automatic void check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endfunction

    task automatic expect_pulse(int len, string req);
        exp_t e;
        e.len = len;
        e.req = req;
        exp_q.push_back(e);
    endtask

    // Monitor: measure each low pulse and compare with the scoreboard
    always @(negedge clk) begin
        exp_t e;
        if (mon_en) begin
            if (!sys_rst_n) begin
                run_len++;
            end else if (run_len > 0) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, {quiet_req, " unexpected pulse"}, run_len, 0);
                end else begin
                    e = exp_q.pop_front();
                    check(run_len == e.len, e.req, run_len, e.len);
                end
                run_len = 0;
            end
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wd_strobe();
        @(negedge clk) wd_fault = 1'b1;
        @(negedge clk) wd_fault = 1'b0;
    endtask

    task automatic mr_press(int len);
        @(negedge clk) mr_n = 1'b0;
        repeat (len) @(negedge clk);
        mr_n = 1'b1;
    endtask

    task automatic uv_dip(int d, int g);
        @(negedge clk);
        uv_flag = 1'b1;
        ok_hyst = 1'b0;
        repeat (d) @(negedge clk);
        uv_flag = 1'b0;
        repeat (g) @(negedge clk);
        ok_hyst = 1'b1;
    endtask

    task automatic check_quiet(int n, string req);
        int lows = 0;
        repeat (n) begin
            @(negedge clk);
            if (!sys_rst_n) lows++;
        end
        check(lows == 0, req, lows, 0);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    // Watchdog for a hung run
    initial begin
        #(8 * 150000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL R1 watchdog expired actual=running expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        int lowcnt;
        idle(5);
        check(sys_rst_n == 1'b0, "R1 output low during block reset", int'(sys_rst_n), 0);
        rst_n = 1'b1;
        lowcnt = 0;
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            if (sys_rst_n) break;
            lowcnt++;
        end
        check(lowcnt == 20, "R1 power-up hold-off length", lowcnt, 20);
        mon_en = 1'b1;
        idle(5);

        // R2: single watchdog strobe, two hold lengths
        expect_pulse(20, "R2 watchdog pulse H=20");
        wd_strobe();
        idle(35);
        cfg_hold_len = 16'd7;
        expect_pulse(7, "R2 watchdog pulse H=7");
        wd_strobe();
        idle(20);

        // R9: zero hold length acts as one cycle
        cfg_hold_len = 16'd0;
        expect_pulse(1, "R9 zero hold gives one-cycle pulse");
        wd_strobe();
        idle(10);
        cfg_hold_len = 16'd20;
        idle(2);

        // R7: second strobe 6 cycles later reloads the hold-off
        expect_pulse(26, "R7 reload during hold-off");
        @(negedge clk) wd_fault = 1'b1;
        @(negedge clk) wd_fault = 1'b0;
        idle(5);
        wd_fault = 1'b1;
        @(negedge clk) wd_fault = 1'b0;
        idle(45);

        // R3: accepted manual presses
        expect_pulse(20, "R3 manual reset at minimum width");
        mr_press(MR_MIN_W);
        idle(40);
        expect_pulse(10 - MR_MIN_W + 20, "R3 long manual reset");
        mr_press(10);
        idle(45);

        // R4: glitches below the minimum width
        quiet_req = "R4";
        mr_press(MR_MIN_W - 1);
        check_quiet(40, "R4 manual glitch one short of width ignored");
        mr_press(1);
        check_quiet(40, "R4 single-cycle manual glitch ignored");
        quiet_req = "R8";

        // R5: qualified dip at exactly N, and a dip one short
        expect_pulse(5 + 1 - 5 + 19, "R5 qualified dip at N");
        uv_dip(5, 1);
        idle(45);
        quiet_req = "R5";
        uv_dip(4, 1);
        check_quiet(40, "R5 short supply dip ignored");
        quiet_req = "R8";

        // R6: release waits for the hysteresis flag
        expect_pulse(8 + 15 - 5 + 19, "R6 release follows recovered flag");
        uv_dip(8, 15);
        idle(60);

        // R5: qualification length 0 acts as 1
        cfg_uv_qual = 8'd0;
        expect_pulse(1 + 1 - 1 + 19, "R5 qualification 0 acts as 1");
        uv_dip(1, 1);
        idle(40);
        cfg_uv_qual = 8'd5;

        // R8: watchdog strobe inside a held manual reset
        expect_pulse(30 - MR_MIN_W + 20, "R8 overlap releases after last cause");
        @(negedge clk) mr_n = 1'b0;
        idle(10);
        wd_fault = 1'b1;
        @(negedge clk) wd_fault = 1'b0;
        idle(19);
        mr_n = 1'b1;
        idle(70);

        check(exp_q.size() == 0, "R8 every expected pulse observed", exp_q.size(), 0);
        finished = 1'b1;
        summary();
        $finish;
    end

endmodule